// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block removes and restores power for up to three switchable power domains when software asks for it. Software reaches it through a 32-bit register bus with word-aligned byte addresses. One global register holds a pair of request bits for each domain. Each domain also has a small register group: a gate-enable bit, two delay pairs (one for power-down, one for power-up) and a status word.

A sequencer inside each domain counts bus clock cycles. It drives two registered outputs for its domain: an isolation clamp and a power-switch-open signal. They change in a safe order. Going down, the clamp is applied first and the switch opens afterwards. Coming up, the switch closes first and the clamp is released afterwards. Each delay is split into two 6-bit counts.

A request bit is set by writing a 1 to it. The hardware clears the bit when its sequence ends, so software polls the bit to see that the work is done.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset, every `iso_o` and `sw_off_o` bit is 0. The global request register reads 0. Each domain's control and status words read 0. Each timing word reads 0x00000101.
- R2: The global request register is at byte 0x000. The domain groups start at 0x260 (domain 0), 0x240 (domain 1) and 0x200 (domain 2). Within a group:
  - Control is at +0x0, with the gate-enable flag in bit 0.
  - Power-up timing is at +0x4: first count in bits [5:0], second count in bits [13:8].
  - Power-down timing is at +0x8, with the same field layout.
  - Status is at +0xC.
  - Every other bit reads 0.
- R3: The power-down request bits sit at positions 0, 4 and 6 of the global register, for domains 0, 1 and 2. Each domain's power-up request bit is one position higher. Writing a 1 sets a request bit, and writing a 0 leaves it unchanged.
- R4: The write edge sets a power-down request on an enabled, powered domain. On the next clock edge, `iso_o` rises. `sw_off_o` then rises exactly A+B cycles later, where A is the first power-down count and B is the second. Isolation stays high throughout.
- R5: The write edge sets a power-up request on a powered-down domain. On the next clock edge, `sw_off_o` falls. `iso_o` then falls exactly A+B cycles later, where A is the first power-up count and B is the second.
- R6: A request bit clears itself on the same edge as the final output change of its sequence. The status word's bit 0 reads 1 from the moment the switch opens until isolation is released.
- R7: A power-down request on a domain whose gate-enable flag is 0 clears one cycle after it is set. It changes neither output.
- R8: When both request bits of a domain are pending, the power-down sequence runs first. The power-up sequence runs after it finishes.
- R9: A request that matches the domain's present state clears one cycle after it is set, with no output change. That is, a power-down when the domain is already down, or a power-up when it is already up.
- R10: Reads of unmapped addresses return 0, and writes to them change nothing. Unmapped addresses include every address with nonzero bits [1:0].
- R11: `sw_off_o` of a domain is never 1 while its `iso_o` is 0.
- R12: A count of 0 is treated as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| iso_o | output | 3 | Isolation clamp per domain, 1 = clamped |
| sw_off_o | output | 3 | Power switch per domain, 1 = open (power removed) |

## Verification
A wrong sequencer state or counter value shows at the ports as an isolation or switch edge that lands one or more cycles away from A+B. A clamp released while the switch is open also shows at the ports. The bench measures these edge distances cycle by cycle.

A request bit that is cleared wrongly, or never cleared, appears at the next read of the global register. Such a read takes two cycles, so the error is seen within a few cycles of the completion edge. A misdecoded address corrupts a neighbouring field, and this surfaces at the read-back that follows the write.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DN_ISO,
    S_DN_SW,
    S_UP_SW,
    S_UP_ISO
  } seq_state_e;

  // word offsets inside one domain group
  localparam int OFS_CTRL = 0;
  localparam int OFS_UPT  = 1;
  localparam int OFS_DNT  = 2;
  localparam int OFS_STAT = 3;
  localparam int GRP_WORDS = 4;

  // byte base of a domain group
  function automatic int unsigned grp_base(input int d);
    case (d)
      0:       return 32'h260;
      1:       return 32'h240;
      default: return 32'h200;
    endcase
  endfunction

  // position of the power-down request bit; power-up is one above
  function automatic int unsigned dn_bit(input int d);
    case (d)
      0:       return 0;
      1:       return 4;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/pgs_regs.sv
module pgs_regs
  import pgs_pkg::*;
#(
  parameter int NUM_DOM = 3,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_en,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [NUM_DOM-1:0]       dn_done,
  input  logic [NUM_DOM-1:0]       up_done,
  input  logic [NUM_DOM-1:0]       is_down,
  output logic [NUM_DOM-1:0]       dn_req,
  output logic [NUM_DOM-1:0]       up_req,
  output logic [NUM_DOM-1:0]       gate_en,
  output logic [NUM_DOM*CNT_W-1:0] up_a,
  output logic [NUM_DOM*CNT_W-1:0] up_b,
  output logic [NUM_DOM*CNT_W-1:0] dn_a,
  output logic [NUM_DOM*CNT_W-1:0] dn_b
);

  localparam int WORD_W = ADDR_W - 2;
  localparam int HI_LSB = 8;
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(1);

  logic [WORD_W-1:0]                 word;
  logic                              aligned;
  logic                              wr;
  logic                              rd;
  logic                              sel_glob;
  logic [NUM_DOM-1:0][GRP_WORDS-1:0] sel;
  logic                              any_hit;
  logic [DATA_W-1:0]                 rd_mux;
  logic                              unused_wdata;

  assign word         = bus_addr[ADDR_W-1:2];
  assign aligned      = (bus_addr[1:0] == 2'b00);
  assign wr           = bus_en & bus_we;
  assign rd           = bus_en & ~bus_we;
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    sel_glob = aligned && (word == '0);
    for (int d = 0; d < NUM_DOM; d++) begin
      for (int k = 0; k < GRP_WORDS; k++) begin
        sel[d][k] = aligned && (word == WORD_W'((grp_base(d) >> 2) + k));
      end
    end
  end

  assign any_hit = sel_glob | (|sel);

  // request bits: set by write-1, cleared by sequencer completion
  always_ff @(posedge clk) begin
    if (rst) begin
      dn_req <= '0;
      up_req <= '0;
    end else begin
      for (int d = 0; d < NUM_DOM; d++) begin
        dn_req[d] <= (dn_req[d] & ~dn_done[d]) |
                     (wr & sel_glob & bus_wdata[dn_bit(d)]);
        up_req[d] <= (up_req[d] & ~up_done[d]) |
                     (wr & sel_glob & bus_wdata[dn_bit(d) + 1]);
      end
    end
  end

  // per-domain configuration words
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_en <= '0;
      up_a    <= {NUM_DOM{CNT_RST}};
      up_b    <= {NUM_DOM{CNT_RST}};
      dn_a    <= {NUM_DOM{CNT_RST}};
      dn_b    <= {NUM_DOM{CNT_RST}};
    end else if (wr) begin
      for (int d = 0; d < NUM_DOM; d++) begin
        if (sel[d][OFS_CTRL]) gate_en[d] <= bus_wdata[0];
        if (sel[d][OFS_UPT]) begin
          up_a[d*CNT_W +: CNT_W] <= bus_wdata[CNT_W-1:0];
          up_b[d*CNT_W +: CNT_W] <= bus_wdata[HI_LSB +: CNT_W];
        end
        if (sel[d][OFS_DNT]) begin
          dn_a[d*CNT_W +: CNT_W] <= bus_wdata[CNT_W-1:0];
          dn_b[d*CNT_W +: CNT_W] <= bus_wdata[HI_LSB +: CNT_W];
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int d = 0; d < NUM_DOM; d++) begin
      if (sel_glob) begin
        rd_mux[dn_bit(d)]     = dn_req[d];
        rd_mux[dn_bit(d) + 1] = up_req[d];
      end
      if (sel[d][OFS_CTRL]) rd_mux[0] = gate_en[d];
      if (sel[d][OFS_UPT]) begin
        rd_mux[CNT_W-1:0]        = up_a[d*CNT_W +: CNT_W];
        rd_mux[HI_LSB +: CNT_W]  = up_b[d*CNT_W +: CNT_W];
      end
      if (sel[d][OFS_DNT]) begin
        rd_mux[CNT_W-1:0]        = dn_a[d*CNT_W +: CNT_W];
        rd_mux[HI_LSB +: CNT_W]  = dn_b[d*CNT_W +: CNT_W];
      end
      if (sel[d][OFS_STAT]) rd_mux[0] = is_down[d];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

  // R10: unmapped read returns zero
  p_unmapped_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd && !any_hit) |=> (bus_rdata == '0));

  // R10: unmapped write leaves configuration untouched
  p_unmapped_write_inert_r10: assert property (@(posedge clk) disable iff (rst)
    (wr && !any_hit) |=> ($stable(gate_en) && $stable(up_a) && $stable(up_b) &&
                          $stable(dn_a) && $stable(dn_b)));

  generate
    for (genvar g = 0; g < NUM_DOM; g++) begin : g_req_chk
      // R6: a request bit only falls on its completion
      p_dn_clear_on_done_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(dn_req[g]) |-> $past(dn_done[g]));
      p_up_clear_on_done_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(up_req[g]) |-> $past(up_done[g]));
    end
  endgenerate

endmodule

// File: rtl/pgs_dom_seq.sv
module pgs_dom_seq
  import pgs_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dn_req,
  input  logic             up_req,
  input  logic             gate_en,
  input  logic [CNT_W-1:0] up_a,
  input  logic [CNT_W-1:0] up_b,
  input  logic [CNT_W-1:0] dn_a,
  input  logic [CNT_W-1:0] dn_b,
  output logic             dn_done,
  output logic             up_done,
  output logic             iso,
  output logic             sw_off,
  output logic             is_down
);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last = (cnt <= CNT_W'(1));

  always_comb begin
    dn_done = 1'b0;
    up_done = 1'b0;
    case (state)
      S_IDLE: begin
        if (dn_req) dn_done = !gate_en || is_down;
        else if (up_req) up_done = !is_down;
      end
      S_DN_SW:  dn_done = last;
      S_UP_ISO: up_done = last;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      iso     <= 1'b0;
      sw_off  <= 1'b0;
      is_down <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (dn_req) begin
            if (gate_en && !is_down) begin
              state <= S_DN_ISO;
              cnt   <= dn_a;
              iso   <= 1'b1;
            end
          end else if (up_req && is_down) begin
            state  <= S_UP_SW;
            cnt    <= up_a;
            sw_off <= 1'b0;
          end
        end
        S_DN_ISO: begin
          if (last) begin
            state <= S_DN_SW;
            cnt   <= dn_b;
          end else cnt <= cnt - 1'b1;
        end
        S_DN_SW: begin
          if (last) begin
            state   <= S_IDLE;
            sw_off  <= 1'b1;
            is_down <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        S_UP_SW: begin
          if (last) begin
            state <= S_UP_ISO;
            cnt   <= up_b;
          end else cnt <= cnt - 1'b1;
        end
        S_UP_ISO: begin
          if (last) begin
            state   <= S_IDLE;
            iso     <= 1'b0;
            is_down <= 1'b0;
          end else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: switch never open without isolation
  p_iso_covers_sw_r11: assert property (@(posedge clk) disable iff (rst)
    sw_off |-> iso);

  // R4: switch opens only after isolation was already applied
  p_sw_opens_after_iso_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_off) |-> $past(iso));

  // R5: isolation drops only once the switch was already closed
  p_iso_drops_after_sw_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(iso) |-> $past(!sw_off));

  // R7: disabled gating leaves outputs alone
  p_gate_off_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && dn_req && !gate_en) |=> ($stable(iso) && $stable(sw_off)));

  // R8: never both completions in one cycle
  p_single_done_r8: assert property (@(posedge clk) disable iff (rst)
    !(dn_done && up_done));

  // R9: power-up on a powered domain changes nothing
  p_match_no_change_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && up_req && !dn_req && !is_down) |=> ($stable(iso) && $stable(sw_off)));

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
  import pgs_pkg::*;
#(
  parameter int NUM_DOM = 3,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [NUM_DOM-1:0] iso_o,
  output logic [NUM_DOM-1:0] sw_off_o
);

  logic [NUM_DOM-1:0]       dn_req;
  logic [NUM_DOM-1:0]       up_req;
  logic [NUM_DOM-1:0]       gate_en;
  logic [NUM_DOM-1:0]       dn_done;
  logic [NUM_DOM-1:0]       up_done;
  logic [NUM_DOM-1:0]       is_down;
  logic [NUM_DOM*CNT_W-1:0] up_a;
  logic [NUM_DOM*CNT_W-1:0] up_b;
  logic [NUM_DOM*CNT_W-1:0] dn_a;
  logic [NUM_DOM*CNT_W-1:0] dn_b;

  pgs_regs #(
    .NUM_DOM (NUM_DOM),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dn_done   (dn_done),
    .up_done   (up_done),
    .is_down   (is_down),
    .dn_req    (dn_req),
    .up_req    (up_req),
    .gate_en   (gate_en),
    .up_a      (up_a),
    .up_b      (up_b),
    .dn_a      (dn_a),
    .dn_b      (dn_b)
  );

  generate
    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
      pgs_dom_seq #(
        .CNT_W (CNT_W)
      ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .dn_req  (dn_req[g]),
        .up_req  (up_req[g]),
        .gate_en (gate_en[g]),
        .up_a    (up_a[g*CNT_W +: CNT_W]),
        .up_b    (up_b[g*CNT_W +: CNT_W]),
        .dn_a    (dn_a[g*CNT_W +: CNT_W]),
        .dn_b    (dn_b[g*CNT_W +: CNT_W]),
        .dn_done (dn_done[g]),
        .up_done (up_done[g]),
        .iso     (iso_o[g]),
        .sw_off  (sw_off_o[g]),
        .is_down (is_down[g])
      );
    end
  endgenerate

endmodule

// File: tb/pwr_gate_seq_bench.sv
module pwr_gate_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  iso_o;
  logic [2:0]  sw_off_o;

  int checks = 0;
  int fails  = 0;
  bit seen_off2 = 0;

  always #4 clk = ~clk;

  pwr_gate_seq u_pwr_gate_seq (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .iso_o     (iso_o),
    .sw_off_o  (sw_off_o)
  );

  always @(negedge clk) if (sw_off_o[2]) seen_off2 = 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    bus_read(a, v);
    chk(v == exp, req, v, exp);
  endtask

  task automatic wait_clear(input logic [31:0] mask, input string req);
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      bus_read(10'h000, v);
      if ((v & mask) == 0) break;
    end
    chk((v & mask) == 0, req, v & mask, 0);
  endtask

  task automatic t_reset;
    chk(iso_o == 0, "R1 iso", iso_o, 0);
    chk(sw_off_o == 0, "R1 sw_off", sw_off_o, 0);
    rd_chk(10'h000, 32'h0, "R1 request reg");
    rd_chk(10'h260, 32'h0, "R1 ctrl");
    rd_chk(10'h264, 32'h101, "R1 up timing");
    rd_chk(10'h268, 32'h101, "R1 down timing");
    rd_chk(10'h26C, 32'h0, "R1 status");
  endtask

  task automatic t_regmap;
    bus_write(10'h244, 32'hFFFF_FFFF);
    rd_chk(10'h244, 32'h0000_3F3F, "R2 field mask");
    bus_write(10'h208, 32'h0000_0A05);
    rd_chk(10'h208, 32'h0000_0A05, "R2 down timing dom2");
    rd_chk(10'h204, 32'h0000_0101, "R2 neighbour untouched");
    bus_write(10'h200, 32'hFFFF_FFFF);
    rd_chk(10'h200, 32'h1, "R2 ctrl only bit0");
    bus_write(10'h200, 32'h0);
  endtask

  task automatic t_unmapped;
    bus_write(10'h210, 32'h1234_5678);
    rd_chk(10'h210, 32'h0, "R10 gap read");
    rd_chk(10'h004, 32'h0, "R10 after global");
    rd_chk(10'h3FC, 32'h0, "R10 top of space");
    bus_write(10'h246, 32'h0);
    rd_chk(10'h244, 32'h0000_3F3F, "R10 misaligned write ignored");
    rd_chk(10'h246, 32'h0, "R10 misaligned read");
  endtask

  task automatic t_gate_disabled;
    bus_write(10'h000, 32'h10);
    repeat (3) @(negedge clk);
    chk(iso_o[1] == 0 && sw_off_o[1] == 0, "R7 outputs unchanged", {iso_o[1], sw_off_o[1]}, 0);
    rd_chk(10'h000, 32'h0, "R7 request cleared");
    rd_chk(10'h24C, 32'h0, "R7 status still powered");
  endtask

  task automatic t_power_down_d0;
    int n = 0;
    bus_write(10'h268, 32'h0000_0403);
    bus_write(10'h260, 32'h1);
    bus_write(10'h000, 32'h1);
    chk(iso_o[0] == 0, "R4 iso not yet", iso_o[0], 0);
    @(negedge clk);
    chk(iso_o[0] == 1 && sw_off_o[0] == 0, "R4 iso first", {iso_o[0], sw_off_o[0]}, 2);
    while (!sw_off_o[0] && n < 100) begin
      @(negedge clk); n++;
      if (!iso_o[0]) chk(0, "R4 iso dropped", 0, 1);
    end
    chk(n == 7, "R4 iso-to-switch cycles", n, 7);
    rd_chk(10'h000, 32'h0, "R6 request self-cleared");
    rd_chk(10'h26C, 32'h1, "R6 status down");
  endtask

  task automatic t_match_d0;
    bus_write(10'h000, 32'h1);
    @(negedge clk);
    chk(iso_o[0] == 1 && sw_off_o[0] == 1, "R9 down again no change", {iso_o[0], sw_off_o[0]}, 3);
    rd_chk(10'h000, 32'h0, "R9 down again cleared");
  endtask

  task automatic t_power_up_d0;
    int n = 0;
    bus_write(10'h264, 32'h0000_0502);
    bus_write(10'h000, 32'h2);
    chk(sw_off_o[0] == 1, "R5 switch not yet", sw_off_o[0], 1);
    @(negedge clk);
    chk(sw_off_o[0] == 0 && iso_o[0] == 1, "R5 switch first", {iso_o[0], sw_off_o[0]}, 2);
    rd_chk(10'h26C, 32'h1, "R6 status down during power-up");
    n = 2;
    while (iso_o[0] && n < 100) begin @(negedge clk); n++; end
    chk(n == 7, "R5 switch-to-iso cycles", n, 7);
    rd_chk(10'h000, 32'h0, "R6 up request cleared");
    rd_chk(10'h26C, 32'h0, "R6 status up");
    bus_write(10'h000, 32'h2);
    repeat (2) @(negedge clk);
    chk(iso_o[0] == 0 && sw_off_o[0] == 0, "R9 up again no change", {iso_o[0], sw_off_o[0]}, 0);
    rd_chk(10'h000, 32'h0, "R9 up again cleared");
  endtask

  task automatic t_zero_counts_d1;
    int n = 0;
    bus_write(10'h248, 32'h0);
    bus_write(10'h240, 32'h1);
    bus_write(10'h000, 32'h10);
    @(negedge clk);
    chk(iso_o[1] == 1, "R12 iso asserted", iso_o[1], 1);
    while (!sw_off_o[1] && n < 100) begin @(negedge clk); n++; end
    chk(n == 2, "R12 zero counts as one", n, 2);
  endtask

  task automatic t_w1s_d2;
    bus_write(10'h208, 32'h0000_1414);
    bus_write(10'h200, 32'h1);
    bus_write(10'h000, 32'h40);
    rd_chk(10'h000, 32'h40, "R3 dom2 down bit 6");
    bus_write(10'h000, 32'h0);
    rd_chk(10'h000, 32'h40, "R3 write zero no effect");
    wait_clear(32'h40, "R3 dom2 completes");
    chk(sw_off_o[2] == 1, "R4 dom2 switch open", sw_off_o[2], 1);
    bus_write(10'h000, 32'h80);
    wait_clear(32'h80, "R3 dom2 up bit 7");
    chk(iso_o[2] == 0 && sw_off_o[2] == 0, "R5 dom2 restored", {iso_o[2], sw_off_o[2]}, 0);
  endtask

  task automatic t_both_d2;
    logic [31:0] v;
    bus_write(10'h208, 32'h0000_0202);
    seen_off2 = 0;
    bus_write(10'h000, 32'hC0);
    bus_read(10'h000, v);
    chk(v == 32'hC0, "R8 both pending", v, 32'hC0);
    chk(iso_o[2] == 1 && sw_off_o[2] == 0, "R8 down runs first", {iso_o[2], sw_off_o[2]}, 2);
    wait_clear(32'hC0, "R8 both completed");
    chk(seen_off2 == 1, "R8 switch was opened", seen_off2, 1);
    chk(iso_o[2] == 0 && sw_off_o[2] == 0, "R8 ends powered", {iso_o[2], sw_off_o[2]}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_regmap();
    t_unmapped();
    t_gate_disabled();
    t_power_down_d0();
    t_match_d0();
    t_power_up_d0();
    t_zero_counts_d1();
    t_w1s_d2();
    t_both_d2();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule